// File: doc/BRIEF.md
# Best Divider Setting Search

This block finds the setting of a two-stage cascaded clock divider that gets closest to a requested output rate without going above it. The divider has a fixed pre-divide, a fixed divide by ten, a power-of-two stage selected by `n`, and an integer stage selected by `m` that divides by `m + M_OFFSET`. Given a parent rate and a target rate, the engine works through all 64 settings in a fixed order. It reports the winning `m`, the winning `n` and the rate that setting actually produces.

Software or a clock-management sequencer pulses `start` with both rates on the inputs. It then waits for the one-cycle `done` pulse and reads the result, which stays on the outputs until the next search is accepted. All arithmetic is unsigned integer arithmetic with truncation. A single multi-cycle restoring divider carries out every division. The shared part of the formula is evaluated once per search.

Top module: `ddc_div_search`

## Requirements
- R1: After reset, `busy` and `done` are low and `best_rate`, `sel_m` and `sel_n` are all zero.
- R2: Each candidate rate is computed with truncation after every step as `base >> n` divided by `m + M_OFFSET`, where `base = (parent_rate / PRE_DIV) / 10`.
- R3: Candidates are visited with `m` in the outer loop from 0 to 7 and `n` in the inner loop from 0 to 7. The winning pair is reported as a 3-bit `sel_m` and a 3-bit `sel_n`.
- R4: A candidate greater than `target_rate` is never chosen, so the reported `best_rate` never exceeds the target.
- R5: A candidate replaces the current best only when it is strictly closer to the target. When two pairs give the same rate, the pair visited first is kept.
- R6: If no candidate is both within the target and strictly closer than zero, the result is rate 0 with `sel_m = 0` and `sel_n = 0`.
- R7: `start` is accepted only while `busy` is low. A `start` pulse during a search is ignored: it neither restarts the search nor produces an extra `done`.
- R8: `done` is high for exactly one cycle per accepted search, and `busy` is low in that cycle.
- R9: While the block is idle, `best_rate`, `sel_m` and `sel_n` hold their values until the next `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a search; sampled only while idle |
| parent_rate | input | 32 | Parent clock rate, captured on an accepted start |
| target_rate | input | 32 | Requested rate, captured on an accepted start |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse when the search completes |
| sel_m | output | 3 | Chosen integer-stage index |
| sel_n | output | 3 | Chosen power-of-two stage index |
| best_rate | output | 32 | Rate produced by the chosen setting |

## Verification
The hardest behaviour to reach from the ports is the tie rule. A tie needs a parent rate for which a later pair gives exactly the same truncated rate as an earlier one, and that shared rate must also be the best one within the target. The stimulus uses a parent rate whose base is 1,200,000. With that base, `m=0,n=1` and `m=1,n=0` both give 600,000, and targets just under 1,200,000 and exactly 600,000 make that pair the winner. A second such collision appears at a tiny base of 9. Ignored starts are reached by pulsing `start` with different rates partway through a search, then confirming that only the first request's result and a single `done` appear.

// File: rtl/ddcsrch_pkg.sv
package ddcsrch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_PRE  = 2'd0,
    PH_TEN  = 2'd1,
    PH_CAND = 2'd2
  } seq_phase_e;

  localparam int unsigned DECADE = 10;

endpackage

// File: rtl/ddcsrch_divider.sv
module ddcsrch_divider #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         ready
);

  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] STEPS = CW'(W);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [W-1:0]  rem_q, rem_n;
  logic [W-1:0]  quo_q, quo_n;
  logic [W-1:0]  dsr_q, dsr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          run_q, run_n;
  logic          rdy_q, rdy_n;

  logic [W:0]    rem_sh;
  logic          fits;
  logic [W-1:0]  rem_sub;
  logic [W-1:0]  rem_step;
  logic [W-1:0]  quo_step;

  // one restoring step: shift in next dividend bit, subtract if it fits
  always_comb begin
    rem_sh   = {rem_q, quo_q[W-1]};
    fits     = (rem_sh >= {1'b0, dsr_q});
    rem_sub  = rem_sh[W-1:0] - dsr_q;
    rem_step = fits ? rem_sub : rem_sh[W-1:0];
    quo_step = {quo_q[W-2:0], fits};
  end

  always_comb begin
    rem_n = rem_q;
    quo_n = quo_q;
    dsr_n = dsr_q;
    cnt_n = cnt_q;
    run_n = run_q;
    rdy_n = 1'b0;
    if (go) begin
      rem_n = '0;
      quo_n = dividend;
      dsr_n = divisor;
      cnt_n = STEPS;
      run_n = 1'b1;
    end else if (run_q) begin
      rem_n = rem_step;
      quo_n = quo_step;
      cnt_n = cnt_q - ONE;
      if (cnt_q == ONE) begin
        run_n = 1'b0;
        rdy_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      dsr_q <= dsr_n;
      cnt_q <= cnt_n;
      run_q <= run_n;
      rdy_q <= rdy_n;
    end
  end

  assign quotient = quo_q;
  assign ready    = rdy_q;

endmodule

// File: rtl/ddcsrch_tracker.sv
module ddcsrch_tracker #(
  parameter int unsigned W      = 32,
  parameter int unsigned M_BITS = 3,
  parameter int unsigned N_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [W-1:0]      cand,
  input  logic [M_BITS-1:0] cand_m,
  input  logic [N_BITS-1:0] cand_n,
  input  logic [W-1:0]      target,
  output logic [W-1:0]      rate,
  output logic [M_BITS-1:0] m_sel,
  output logic [N_BITS-1:0] n_sel
);

  logic [W-1:0]      rate_q;
  logic [M_BITS-1:0] m_q;
  logic [N_BITS-1:0] n_q;
  logic              in_range;
  logic              closer;
  logic              take_en;

  // every kept candidate is at or below target, so "strictly closer"
  // reduces to "strictly larger than the current best"
  always_comb begin
    in_range = (cand <= target);
    closer   = (cand > rate_q);
    take_en  = upd && in_range && closer;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      m_q    <= '0;
      n_q    <= '0;
    end else if (clr) begin
      rate_q <= '0;
      m_q    <= '0;
      n_q    <= '0;
    end else if (take_en) begin
      rate_q <= cand;
      m_q    <= cand_m;
      n_q    <= cand_n;
    end
  end

  assign rate  = rate_q;
  assign m_sel = m_q;
  assign n_sel = n_q;

endmodule

// File: rtl/ddcsrch_seq.sv
module ddcsrch_seq
  import ddcsrch_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned M_BITS   = 3,
  parameter int unsigned N_BITS   = 3,
  parameter int unsigned PRE_DIV  = 2,
  parameter int unsigned M_OFFSET = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W-1:0]      parent_rate,
  input  logic [W-1:0]      target_rate,
  output logic              div_go,
  output logic [W-1:0]      div_dividend,
  output logic [W-1:0]      div_divisor,
  input  logic              div_ready,
  input  logic [W-1:0]      div_quotient,
  output logic              trk_clr,
  output logic              trk_upd,
  output logic [M_BITS-1:0] cand_m,
  output logic [N_BITS-1:0] cand_n,
  output logic [W-1:0]      target_q,
  output logic              busy,
  output logic              done
);

  localparam int unsigned IDX_W = M_BITS + N_BITS;
  localparam logic [IDX_W-1:0] IDX_LAST = '1;
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
  localparam logic [W-1:0] PRE_K  = W'(PRE_DIV);
  localparam logic [W-1:0] TEN_K  = W'(DECADE);
  localparam logic [W-1:0] MOFF_K = W'(M_OFFSET);

  seq_state_e       state_q, state_n;
  seq_phase_e       phase_q, phase_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             done_q, done_n;

  logic [W-1:0]     parent_q;
  logic [W-1:0]     tgt_q;
  logic [W-1:0]     pre_q;
  logic [W-1:0]     base_q;

  logic             accept;
  logic             step_ok;
  logic             cap_en;
  logic             pre_en;
  logic             base_en;

  always_comb begin
    accept  = (state_q == ST_IDLE) && start;
    step_ok = (state_q == ST_WAIT) && div_ready;
    cap_en  = accept;
    pre_en  = step_ok && (phase_q == PH_PRE);
    base_en = step_ok && (phase_q == PH_TEN);
  end

  // next-state logic
  always_comb begin
    state_n = state_q;
    phase_n = phase_q;
    idx_n   = idx_q;
    done_n  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_ISSUE;
          phase_n = PH_PRE;
          idx_n   = '0;
        end
      end
      ST_ISSUE: begin
        state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (div_ready) begin
          case (phase_q)
            PH_PRE: begin
              phase_n = PH_TEN;
              state_n = ST_ISSUE;
            end
            PH_TEN: begin
              phase_n = PH_CAND;
              state_n = ST_ISSUE;
            end
            default: begin
              if (idx_q == IDX_LAST) begin
                state_n = ST_IDLE;
                done_n  = 1'b1;
              end else begin
                idx_n   = idx_q + IDX_ONE;
                state_n = ST_ISSUE;
              end
            end
          endcase
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_PRE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      idx_q   <= idx_n;
      done_q  <= done_n;
    end
  end

  // captured operands and the shared prefix, each with its own enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parent_q <= '0;
      tgt_q    <= '0;
    end else if (cap_en) begin
      parent_q <= parent_rate;
      tgt_q    <= target_rate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_en) begin
      pre_q <= div_quotient;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= div_quotient;
    end
  end

  // operand selection for the shared divider
  always_comb begin
    cand_m = idx_q[IDX_W-1:N_BITS];
    cand_n = idx_q[N_BITS-1:0];
    case (phase_q)
      PH_PRE: begin
        div_dividend = parent_q;
        div_divisor  = PRE_K;
      end
      PH_TEN: begin
        div_dividend = pre_q;
        div_divisor  = TEN_K;
      end
      default: begin
        div_dividend = base_q >> cand_n;
        div_divisor  = W'(cand_m) + MOFF_K;
      end
    endcase
  end

  assign div_go   = (state_q == ST_ISSUE);
  assign trk_clr  = accept;
  assign trk_upd  = step_ok && (phase_q == PH_CAND);
  assign target_q = tgt_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;

endmodule

// File: rtl/ddc_div_search.sv
module ddc_div_search #(
  parameter int unsigned W        = 32,
  parameter int unsigned M_BITS   = 3,
  parameter int unsigned N_BITS   = 3,
  parameter int unsigned PRE_DIV  = 2,
  parameter int unsigned M_OFFSET = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W-1:0]      parent_rate,
  input  logic [W-1:0]      target_rate,
  output logic              busy,
  output logic              done,
  output logic [M_BITS-1:0] sel_m,
  output logic [N_BITS-1:0] sel_n,
  output logic [W-1:0]      best_rate
);

  logic              div_go;
  logic [W-1:0]      div_dividend;
  logic [W-1:0]      div_divisor;
  logic              div_ready;
  logic [W-1:0]      div_quotient;
  logic              trk_clr;
  logic              trk_upd;
  logic [M_BITS-1:0] cand_m;
  logic [N_BITS-1:0] cand_n;
  logic [W-1:0]      target_q;

  ddcsrch_seq #(
    .W(W), .M_BITS(M_BITS), .N_BITS(N_BITS),
    .PRE_DIV(PRE_DIV), .M_OFFSET(M_OFFSET)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .parent_rate  (parent_rate),
    .target_rate  (target_rate),
    .div_go       (div_go),
    .div_dividend (div_dividend),
    .div_divisor  (div_divisor),
    .div_ready    (div_ready),
    .div_quotient (div_quotient),
    .trk_clr      (trk_clr),
    .trk_upd      (trk_upd),
    .cand_m       (cand_m),
    .cand_n       (cand_n),
    .target_q     (target_q),
    .busy         (busy),
    .done         (done)
  );

  ddcsrch_divider #(
    .W(W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_dividend),
    .divisor  (div_divisor),
    .quotient (div_quotient),
    .ready    (div_ready)
  );

  ddcsrch_tracker #(
    .W(W), .M_BITS(M_BITS), .N_BITS(N_BITS)
  ) u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (trk_clr),
    .upd    (trk_upd),
    .cand   (div_quotient),
    .cand_m (cand_m),
    .cand_n (cand_n),
    .target (target_q),
    .rate   (best_rate),
    .m_sel  (sel_m),
    .n_sel  (sel_n)
  );

endmodule

// File: rtl/ddcsrch_chk.sv
module ddcsrch_chk #(
  parameter int unsigned W      = 32,
  parameter int unsigned M_BITS = 3,
  parameter int unsigned N_BITS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [W-1:0]      target_rate,
  input logic              busy,
  input logic              done,
  input logic [M_BITS-1:0] sel_m,
  input logic [N_BITS-1:0] sel_n,
  input logic [W-1:0]      best_rate
);

  logic [W-1:0] tgt_seen;
  logic [1:0]   pend;
  logic         acc;

  assign acc = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_seen <= '0;
    end else if (acc) begin
      tgt_seen <= target_rate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 2'd0;
    end else begin
      pend <= pend + {1'b0, acc} - {1'b0, done};
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_start_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);

  assert_one_search_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pend == 2'd1));

  assert_not_over_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (best_rate <= tgt_seen));

  assert_empty_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (best_rate == '0)) |-> ((sel_m == '0) && (sel_n == '0)));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> ($stable(best_rate) && $stable(sel_m) && $stable(sel_n)));

endmodule

bind ddc_div_search ddcsrch_chk #(
  .W(W), .M_BITS(M_BITS), .N_BITS(N_BITS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .target_rate (target_rate),
  .busy        (busy),
  .done        (done),
  .sel_m       (sel_m),
  .sel_n       (sel_n),
  .best_rate   (best_rate)
);

// File: tb/sim_ddc_div_search.sv
`timescale 1ns/1ps
module sim_ddc_div_search;

  localparam int unsigned PRE  = 2;
  localparam int unsigned MOFF = 1;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] parent_rate;
  logic [31:0] target_rate;
  logic        busy;
  logic        done;
  logic [2:0]  sel_m;
  logic [2:0]  sel_n;
  logic [31:0] best_rate;

  typedef struct {
    logic [31:0] rate;
    logic [2:0]  m;
    logic [2:0]  n;
    string       req;
  } exp_t;

  exp_t sb[$];
  int   n_chk;
  int   n_bad;
  int   n_done;
  bit   prev_done;
  bit   finished;

  ddc_div_search #(.PRE_DIV(PRE), .M_OFFSET(MOFF)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .parent_rate(parent_rate), .target_rate(target_rate),
    .busy(busy), .done(done), .sel_m(sel_m), .sel_n(sel_n),
    .best_rate(best_rate)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // expected result from the requirement text
  function automatic exp_t model(input logic [31:0] p, input logic [31:0] t);
    exp_t r;
    logic [31:0] base;
    logic [31:0] c;
    base   = (p / PRE) / 10;
    r.rate = 0;
    r.m    = 0;
    r.n    = 0;
    r.req  = "R2";
    for (int m = 0; m < 8; m++) begin
      for (int n = 0; n < 8; n++) begin
        c = (base >> n) / (m + MOFF);
        if (c <= t && (t - c) < (t - r.rate)) begin
          r.rate = c;
          r.m    = 3'(m);
          r.n    = 3'(n);
        end
      end
    end
    return r;
  endfunction

  // monitor: compare each completed search with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        n_done++;
        check(!prev_done, "R8", "done width", 2, 1);
        check(!busy, "R8", "busy during done", longint'(busy), 0);
        if (sb.size() == 0) begin
          check(1'b0, "R7", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(best_rate == e.rate, e.req, "rate", best_rate, e.rate);
          check(sel_m == e.m, e.req, "m", sel_m, e.m);
          check(sel_n == e.n, e.req, "n", sel_n, e.n);
        end
      end
      prev_done = done;
    end
  end

  task automatic run_search(input logic [31:0] p, input logic [31:0] t,
                            input string req);
    exp_t e;
    e     = model(p, t);
    e.req = req;
    sb.push_back(e);
    @(negedge clk);
    parent_rate = p;
    target_rate = t;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input logic [31:0] r, input logic [2:0] m,
                            input logic [2:0] n, input string req);
    check(best_rate == r, req, "fixed rate", best_rate, r);
    check(sel_m == m, req, "fixed m", sel_m, m);
    check(sel_n == n, req, "fixed n", sel_n, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "timeout", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] keep_rate;
    logic [2:0]  keep_m;
    logic [2:0]  keep_n;
    int          d0;
    n_chk = 0; n_bad = 0; n_done = 0; prev_done = 0; finished = 0;
    start = 0; parent_rate = 0; target_rate = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0, "R1", "busy", busy, 0);
    check(done == 0, "R1", "done", done, 0);
    check(best_rate == 0, "R1", "rate", best_rate, 0);
    check(sel_m == 0 && sel_n == 0, "R1", "m,n", {sel_m, sel_n}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R3: exact hit at a later pair (base 1,200,000)
    run_search(32'd24_000_000, 32'd100_000, "R3");
    expect_out(32'd100_000, 3'd2, 3'd2, "R3");
    // R5: tie between m0n1 and m1n0, first visited kept
    run_search(32'd24_000_000, 32'd600_000, "R5");
    expect_out(32'd600_000, 3'd0, 3'd1, "R5");
    // R4: top candidate just over target is rejected
    run_search(32'd24_000_000, 32'd1_199_999, "R4");
    expect_out(32'd600_000, 3'd0, 3'd1, "R4");
    // R6: every candidate above a zero target
    run_search(32'd24_000_000, 32'd0, "R6");
    expect_out(32'd0, 3'd0, 3'd0, "R6");
    // R6: base truncates to zero
    run_search(32'd15, 32'd1000, "R6");
    expect_out(32'd0, 3'd0, 3'd0, "R6");
    // R2: full-range operands, truncated prefix
    run_search(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    expect_out(32'd214_748_364, 3'd0, 3'd0, "R2");
    // R2 and R5 at a tiny base of 9
    run_search(32'd199, 32'd4, "R5");
    expect_out(32'd4, 3'd0, 3'd1, "R5");
    run_search(32'd199, 32'd3, "R2");
    expect_out(32'd3, 3'd2, 3'd0, "R2");

    // R9: result holds while idle
    keep_rate = best_rate; keep_m = sel_m; keep_n = sel_n;
    repeat (40) @(negedge clk);
    check(best_rate == keep_rate, "R9", "rate hold", best_rate, keep_rate);
    check(sel_m == keep_m && sel_n == keep_n, "R9", "m,n hold",
          {sel_m, sel_n}, {keep_m, keep_n});

    // R7: start during a search is ignored
    d0 = n_done;
    begin
      exp_t e;
      e = model(32'd24_000_000, 32'd100_000);
      e.req = "R7";
      sb.push_back(e);
    end
    @(negedge clk);
    parent_rate = 32'd24_000_000; target_rate = 32'd100_000; start = 1;
    @(negedge clk);
    start = 0;
    repeat (300) @(negedge clk);
    check(busy == 1, "R7", "busy mid-search", busy, 1);
    parent_rate = 32'd199; target_rate = 32'd3; start = 1;
    @(negedge clk);
    start = 0;
    while (sb.size() != 0) @(negedge clk);
    repeat (200) @(negedge clk);
    check(n_done - d0 == 1, "R7", "done count", n_done - d0, 1);
    expect_out(32'd100_000, 3'd2, 3'd2, "R7");

    // R2 and R4: pseudo-random operands against the model
    lfsr = 32'h1357_9BDF;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] p;
      logic [31:0] t;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      p    = lfsr;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      t    = (i % 2 == 0) ? (lfsr >> (lfsr[3:0] + 4)) : (lfsr >> 8);
      run_search(p, t, (i % 2 == 0) ? "R4" : "R2");
      check(best_rate <= t, "R4", "not over target", best_rate, t);
    end

    finish_run();
  end

endmodule